// File: doc/BRIEF.md
# Signed/Unsigned 64-by-32 Integer Divider

This block divides a 64-bit dividend, given as a high and a low word, by a 32-bit divisor. A mode input selects two's-complement or unsigned interpretation. It returns a 32-bit quotient, a 32-bit remainder and a five-bit condition-code vector that follows processor rules. The caller supplies the condition codes that were in force before the division, and the block decides which of those bits pass through unchanged.

An operation begins with a one-cycle `start` pulse while the block is idle. Two cases are settled in the first cycle: a zero divisor, and a high dividend word that already shows the quotient cannot fit. Every other case runs a restoring shift-subtract loop that produces one quotient bit per clock. A final sign-correction stage can still report overflow when the signed quotient falls outside the 32-bit range. In every fault case the original dividend words are returned in place of a result. `done` pulses for one cycle when the registered outputs become valid. The outputs then hold until the next result.

Top module: `wide_divider`

## Requirements
- R1: A zero divisor finishes with `done` one cycle after `start`. `rem_out` holds the dividend high word, `quo_out` holds the dividend low word, `flags_out` equals `flags_in` unchanged, and `div_zero` is 1.
- R2: In unsigned mode (`signed_mode`=0) with no fault, `quo_out` is the floor of dividend/divisor and `rem_out` is the remainder, which is less than the divisor. `done` rises W+2 cycles after `start`.
- R3: Overflow is declared in the first cycle, with `done` one cycle after `start`, when the high word of the dividend magnitude is greater than or equal to the divisor magnitude, compared unsigned.
- R4: In signed mode (`signed_mode`=1) both operands are divided as magnitudes. The remainder carries the sign of the dividend, and the quotient is negative exactly when the operand signs differ.
- R5: In signed mode, a quotient whose magnitude exceeds 0x80000000 is an overflow when it is negative. A positive quotient is an overflow when bit 31 of its magnitude is set. This check finishes at the normal latency of W+2 cycles.
- R6: On overflow, `rem_out` holds the dividend high word and `quo_out` holds the dividend low word, and `ovf` is 1. In `flags_out`, V (bit 1) is 1 and C (bit 0) is 0, while X (bit 4), N (bit 3) and Z (bit 2) keep their values from `flags_in`.
- R7: On normal completion, X (bit 4) keeps its incoming value, N (bit 3) equals bit 31 of `quo_out`, Z (bit 2) is 1 exactly when `quo_out` is zero, and V and C are 0.
- R8: A zero dividend gives a quotient of 0 and a remainder of 0. A dividend with a zero high word that is smaller than the divisor gives a quotient of 0 and a remainder equal to the dividend.
- R9: `start` has no effect while `busy` is 1. The result that completes belongs to the operands taken when the block was idle.
- R10: `done` is high for exactly one cycle per operation, `busy` is low whenever `done` is high, and the outputs hold their values until the next `done`.
- R11: Synchronous reset returns the block to idle with `busy`, `done`, `div_zero`, `ovf`, `rem_out`, `quo_out` and `flags_out` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; taken only while idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dvd_hi | input | W | Dividend high word |
| dvd_lo | input | W | Dividend low word |
| dvs | input | W | Divisor |
| flags_in | input | 5 | Incoming condition codes {X,N,Z,V,C} |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: result valid |
| rem_out | output | W | Remainder, or dividend high word on a fault |
| quo_out | output | W | Quotient, or dividend low word on a fault |
| flags_out | output | 5 | Resulting condition codes {X,N,Z,V,C} |
| div_zero | output | 1 | Last operation had a zero divisor |
| ovf | output | 1 | Last operation overflowed |

## Verification
A wrong partial remainder or a miscounted step cannot stay hidden inside the loop. It appears at the ports W+2 cycles after `start`, either as a wrong quotient or remainder or as `done` arriving on the wrong cycle. Because the bench predicts the exact completion cycle, either fault is caught on that cycle. A mis-latched sign, or mis-latched incoming flags, shows up in the same `done` cycle as a wrongly signed result or a wrongly preserved X/N/Z bit. A wrong fast-path decision shows up one cycle after `start`, as a `done` that arrives too early or is missing.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wdiv_state_e;

  localparam int unsigned FLW  = 5;
  localparam int unsigned FL_X = 4;
  localparam int unsigned FL_N = 3;
  localparam int unsigned FL_Z = 2;
  localparam int unsigned FL_V = 1;
  localparam int unsigned FL_C = 0;
endpackage

// File: rtl/wdiv_prep.sv
// Operand conditioning: magnitudes, sign capture and first-cycle fault checks.
module wdiv_prep #(
  parameter int unsigned W = 32
) (
  input  logic           sgn,
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   dvs,
  output logic [W-1:0]   mag_hi,
  output logic [W-1:0]   mag_lo,
  output logic [W-1:0]   mag_dvs,
  output logic           neg_dvd,
  output logic           neg_dvs,
  output logic           zero_dvs,
  output logic           early_ovf
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] dvd_raw;
  logic [DW-1:0] dvd_mag;

  always_comb begin
    dvd_raw   = {hi, lo};
    neg_dvd   = sgn & hi[W-1];
    neg_dvs   = sgn & dvs[W-1];
    dvd_mag   = neg_dvd ? (~dvd_raw + DW'(1)) : dvd_raw;
    mag_dvs   = neg_dvs ? (~dvs + W'(1)) : dvs;
    mag_hi    = dvd_mag[DW-1:W];
    mag_lo    = dvd_mag[W-1:0];
    zero_dvs  = (dvs == '0);
    early_ovf = (mag_hi >= mag_dvs);
  end
endmodule

// File: rtl/wdiv_core.sv
// Restoring shift-subtract loop: one quotient bit per clock, W steps.
module wdiv_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] qmag,
  output logic [W-1:0] rmag,
  output logic         fin
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  part_r;
  logic [W-1:0]  shq;
  logic [W-1:0]  dreg;
  logic [CW-1:0] cnt;
  logic          active;

  logic [W:0]    trial;
  logic          fits;
  logic [W:0]    diff;

  always_comb begin
    trial = {part_r, shq[W-1]};
    fits  = (trial >= {1'b0, dreg});
    diff  = trial - {1'b0, dreg};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part_r <= '0;
      shq    <= '0;
      dreg   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        part_r <= hi;
        shq    <= lo;
        dreg   <= dvs;
        cnt    <= '0;
        active <= 1'b1;
      end else if (active) begin
        part_r <= fits ? diff[W-1:0] : trial[W-1:0];
        shq    <= {shq[W-2:0], fits};
        cnt    <= cnt + CW'(1);
        if (cnt == CW'(W - 1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign qmag = shq;
  assign rmag = part_r;
endmodule

// File: rtl/wdiv_post.sv
// Sign restoration, signed range check and condition-code formation.
module wdiv_post #(
  parameter int unsigned W = 32
) (
  input  logic                   sgn,
  input  logic                   neg_dvd,
  input  logic                   neg_dvs,
  input  logic [W-1:0]           qmag,
  input  logic [W-1:0]           rmag,
  input  logic [W-1:0]           orig_hi,
  input  logic [W-1:0]           orig_lo,
  input  logic [wdiv_pkg::FLW-1:0] fl_in,
  output logic [W-1:0]           rem_res,
  output logic [W-1:0]           quo_res,
  output logic [wdiv_pkg::FLW-1:0] fl_res,
  output logic                   range_ovf
);
  import wdiv_pkg::*;

  localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

  logic         neg_q;
  logic [W-1:0] q_s;
  logic [W-1:0] r_s;

  always_comb begin
    neg_q     = neg_dvd ^ neg_dvs;
    q_s       = neg_q ? (~qmag + W'(1)) : qmag;
    r_s       = neg_dvd ? (~rmag + W'(1)) : rmag;
    range_ovf = sgn & (neg_q ? (qmag > MIN_MAG) : qmag[W-1]);
    fl_res    = '0;
    fl_res[FL_X] = fl_in[FL_X];
    if (range_ovf) begin
      rem_res      = orig_hi;
      quo_res      = orig_lo;
      fl_res[FL_N] = fl_in[FL_N];
      fl_res[FL_Z] = fl_in[FL_Z];
      fl_res[FL_V] = 1'b1;
    end else begin
      rem_res      = r_s;
      quo_res      = q_s;
      fl_res[FL_N] = q_s[W-1];
      fl_res[FL_Z] = (q_s == '0);
    end
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider #(
  parameter int unsigned W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     signed_mode,
  input  logic [W-1:0]             dvd_hi,
  input  logic [W-1:0]             dvd_lo,
  input  logic [W-1:0]             dvs,
  input  logic [wdiv_pkg::FLW-1:0] flags_in,
  output logic                     busy,
  output logic                     done,
  output logic [W-1:0]             rem_out,
  output logic [W-1:0]             quo_out,
  output logic [wdiv_pkg::FLW-1:0] flags_out,
  output logic                     div_zero,
  output logic                     ovf
);
  import wdiv_pkg::*;

  wdiv_state_e state;

  logic [W-1:0]   p_mag_hi, p_mag_lo, p_mag_dvs;
  logic           p_neg_dvd, p_neg_dvs, p_zero, p_eovf;

  logic           c_sgn, c_neg_dvd, c_neg_dvs;
  logic [W-1:0]   c_hi, c_lo;
  logic [FLW-1:0] c_fl;

  logic [W-1:0]   k_q, k_r;
  logic           k_fin;
  logic           k_load;

  logic [W-1:0]   s_rem, s_quo;
  logic [FLW-1:0] s_fl;
  logic           s_ovf;

  logic           accept;

  wdiv_prep #(.W(W)) u_prep (
    .sgn       (signed_mode),
    .hi        (dvd_hi),
    .lo        (dvd_lo),
    .dvs       (dvs),
    .mag_hi    (p_mag_hi),
    .mag_lo    (p_mag_lo),
    .mag_dvs   (p_mag_dvs),
    .neg_dvd   (p_neg_dvd),
    .neg_dvs   (p_neg_dvs),
    .zero_dvs  (p_zero),
    .early_ovf (p_eovf)
  );

  assign accept = (state == ST_IDLE) && start;
  assign k_load = accept && !p_zero && !p_eovf;

  wdiv_core #(.W(W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .load (k_load),
    .hi   (p_mag_hi),
    .lo   (p_mag_lo),
    .dvs  (p_mag_dvs),
    .qmag (k_q),
    .rmag (k_r),
    .fin  (k_fin)
  );

  wdiv_post #(.W(W)) u_post (
    .sgn       (c_sgn),
    .neg_dvd   (c_neg_dvd),
    .neg_dvs   (c_neg_dvs),
    .qmag      (k_q),
    .rmag      (k_r),
    .orig_hi   (c_hi),
    .orig_lo   (c_lo),
    .fl_in     (c_fl),
    .rem_res   (s_rem),
    .quo_res   (s_quo),
    .fl_res    (s_fl),
    .range_ovf (s_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      rem_out   <= '0;
      quo_out   <= '0;
      flags_out <= '0;
      div_zero  <= 1'b0;
      ovf       <= 1'b0;
      c_sgn     <= 1'b0;
      c_neg_dvd <= 1'b0;
      c_neg_dvs <= 1'b0;
      c_hi      <= '0;
      c_lo      <= '0;
      c_fl      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            c_sgn     <= signed_mode;
            c_neg_dvd <= p_neg_dvd;
            c_neg_dvs <= p_neg_dvs;
            c_hi      <= dvd_hi;
            c_lo      <= dvd_lo;
            c_fl      <= flags_in;
            if (p_zero) begin
              rem_out   <= dvd_hi;
              quo_out   <= dvd_lo;
              flags_out <= flags_in;
              div_zero  <= 1'b1;
              ovf       <= 1'b0;
              done      <= 1'b1;
            end else if (p_eovf) begin
              rem_out   <= dvd_hi;
              quo_out   <= dvd_lo;
              flags_out <= {flags_in[FL_X], flags_in[FL_N], flags_in[FL_Z], 1'b1, 1'b0};
              div_zero  <= 1'b0;
              ovf       <= 1'b1;
              done      <= 1'b1;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (k_fin) begin
            rem_out   <= s_rem;
            quo_out   <= s_quo;
            flags_out <= s_fl;
            div_zero  <= 1'b0;
            ovf       <= s_ovf;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/wdiv_chk.sv
module wdiv_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         signed_mode,
  input logic [W-1:0] dvd_hi,
  input logic [W-1:0] dvd_lo,
  input logic [W-1:0] dvs,
  input logic [4:0]   flags_in,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] rem_out,
  input logic [W-1:0] quo_out,
  input logic [4:0]   flags_out,
  input logic         div_zero,
  input logic         ovf
);
  logic [W-1:0] k_hi, k_lo, k_dvs;
  logic [4:0]   k_fl;
  logic         k_sgn;
  logic         was_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_hi     <= '0;
      k_lo     <= '0;
      k_dvs    <= '0;
      k_fl     <= '0;
      k_sgn    <= 1'b0;
      was_idle <= 1'b1;
    end else begin
      if (start && was_idle && !busy) begin
        k_hi  <= dvd_hi;
        k_lo  <= dvd_lo;
        k_dvs <= dvs;
        k_fl  <= flags_in;
        k_sgn <= signed_mode;
      end
      was_idle <= 1'b1;
    end
  end

  // R1
  p_zero_div_r1: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> (flags_out == k_fl && rem_out == k_hi && quo_out == k_lo && !ovf));

  // R6
  p_ovf_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (done && ovf) |-> (flags_out[1] && !flags_out[0] && flags_out[4:2] == k_fl[4:2]
                       && rem_out == k_hi && quo_out == k_lo));

  // R7
  p_normal_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !ovf && !div_zero) |-> (flags_out[4] == k_fl[4] && flags_out[3] == quo_out[W-1]
                                     && flags_out[2] == (quo_out == '0) && flags_out[1:0] == 2'b00));

  // R2
  p_unsigned_identity_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !ovf && !div_zero && !k_sgn) |->
      (({{W{1'b0}}, quo_out} * {{W{1'b0}}, k_dvs} + {{W{1'b0}}, rem_out}) == {k_hi, k_lo}
       && rem_out < k_dvs));

  // R10
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!done && !rst && $past(!rst)) |-> ($stable(rem_out) || $past(done) == 1'b0));
endmodule

bind wide_divider wdiv_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .signed_mode (signed_mode),
  .dvd_hi      (dvd_hi),
  .dvd_lo      (dvd_lo),
  .dvs         (dvs),
  .flags_in    (flags_in),
  .busy        (busy),
  .done        (done),
  .rem_out     (rem_out),
  .quo_out     (quo_out),
  .flags_out   (flags_out),
  .div_zero    (div_zero),
  .ovf         (ovf)
);

// File: tb/sim_wide_divider.sv
`timescale 1ns/1ps
module sim_wide_divider;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dvd_hi = '0;
  logic [W-1:0] dvd_lo = '0;
  logic [W-1:0] dvs = '0;
  logic [4:0]   flags_in = '0;
  logic         busy, done, div_zero, ovf;
  logic [W-1:0] rem_out, quo_out;
  logic [4:0]   flags_out;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wide_divider #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs), .flags_in(flags_in),
    .busy(busy), .done(done), .rem_out(rem_out), .quo_out(quo_out),
    .flags_out(flags_out), .div_zero(div_zero), .ovf(ovf)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural model: predicts result, flags and completion cycle, then
  // compares done/busy on every clock until one cycle past completion.
  task automatic do_op(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] d,
                       input logic sg, input logic [4:0] fl, input string req, input bit poke);
    logic [63:0] dd, mag, qm, rm;
    logic [31:0] md, e_rem, e_quo;
    logic [4:0]  e_fl;
    logic        nd, nv, e_dz, e_ov, negq;
    int          lat;
    dd = {hi, lo};
    nd = sg & hi[31];
    nv = sg & d[31];
    mag = nd ? -dd : dd;
    md = nv ? -d : d;
    e_dz = 1'b0; e_ov = 1'b0;
    if (d == 0) begin
      e_dz = 1'b1; lat = 1; e_rem = hi; e_quo = lo; e_fl = fl;
    end else if (mag[63:32] >= md) begin
      e_ov = 1'b1; lat = 1; e_rem = hi; e_quo = lo; e_fl = {fl[4:2], 2'b10};
    end else begin
      lat = W + 2;
      qm = mag / {32'd0, md};
      rm = mag % {32'd0, md};
      negq = nd ^ nv;
      e_ov = sg && (negq ? (qm > 64'h8000_0000) : qm[31]);
      if (e_ov) begin
        e_rem = hi; e_quo = lo; e_fl = {fl[4:2], 2'b10};
      end else begin
        e_quo = negq ? -qm[31:0] : qm[31:0];
        e_rem = nd ? -rm[31:0] : rm[31:0];
        e_fl  = {fl[4], e_quo[31], (e_quo == 0), 2'b00};
      end
    end
    dvd_hi = hi; dvd_lo = lo; dvs = d; signed_mode = sg; flags_in = fl; start = 1'b1;
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (k < lat) begin
        chk(req, "done early", {63'd0, done}, 64'd0);
        chk(req, "busy", {63'd0, busy}, 64'd1);
      end else if (k == lat) begin
        chk("R10", "done", {63'd0, done}, 64'd1);
        chk("R10", "busy at done", {63'd0, busy}, 64'd0);
        chk(req, "rem", {32'd0, rem_out}, {32'd0, e_rem});
        chk(req, "quo", {32'd0, quo_out}, {32'd0, e_quo});
        chk(req, "flags", {59'd0, flags_out}, {59'd0, e_fl});
        chk(req, "div_zero", {63'd0, div_zero}, {63'd0, e_dz});
        chk(req, "ovf", {63'd0, ovf}, {63'd0, e_ov});
      end else begin
        chk("R10", "done pulse", {63'd0, done}, 64'd0);
        chk("R10", "hold quo", {32'd0, quo_out}, {32'd0, e_quo});
      end
      // R9: a start with different operands while busy must be ignored
      if (poke && lat > 3 && k == 2) begin
        start = 1'b1; dvd_hi = ~hi; dvd_lo = ~lo; dvs = d + 32'd3; signed_mode = ~sg;
      end
      if (poke && lat > 3 && k == 3) start = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: run did not end");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11", "busy", {63'd0, busy}, 64'd0);
    chk("R11", "done", {63'd0, done}, 64'd0);
    chk("R11", "outputs", {rem_out, quo_out}, 64'd0);
    chk("R11", "flags", {57'd0, flags_out, div_zero, ovf}, 64'd0);

    do_op(32'h0000_0001, 32'h0000_0000, 32'd2, 1'b0, 5'b00000, "R2", 1'b0);
    do_op(32'h1234_5678, 32'h9ABC_DEF0, 32'h8765_4321, 1'b0, 5'b10000, "R2", 1'b0);
    do_op(32'h0, 32'h0, 32'd5, 1'b0, 5'b10011, "R8", 1'b0);
    do_op(32'h0, 32'd3, 32'd7, 1'b0, 5'b00000, "R8", 1'b0);
    do_op(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'd0, 1'b1, 5'b10101, "R1", 1'b0);
    do_op(32'd5, 32'd1, 32'd5, 1'b0, 5'b11100, "R3", 1'b0);
    do_op(32'h8000_0000, 32'h0, 32'h8000_0000, 1'b1, 5'b01100, "R3", 1'b0);
    do_op(32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 1'b1, 5'b00000, "R4", 1'b0);
    do_op(32'h0, 32'd100, 32'hFFFF_FFF9, 1'b1, 5'b10000, "R4", 1'b0);
    do_op(32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 1'b1, 5'b00000, "R4", 1'b0);
    do_op(32'h0, 32'h8000_0000, 32'd1, 1'b1, 5'b10100, "R5", 1'b0);
    do_op(32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1'b1, 5'b00000, "R5", 1'b0);
    do_op(32'h0, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 5'b01000, "R6", 1'b0);
    do_op(32'h0000_0003, 32'h0000_0042, 32'h0000_0100, 1'b0, 5'b00100, "R7", 1'b0);
    do_op(32'h0000_0ABC, 32'h1234_5678, 32'h0001_0000, 1'b0, 5'b00000, "R9", 1'b1);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] rh, rl, rd;
      rd = $urandom | 32'd1;
      rh = $urandom;
      rl = $urandom;
      if (rh >= rd) rh = rh % rd;
      do_op(rh, rl, rd, i[0], 5'(i * 7), "R2", 1'b0);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule